// File: doc/BRIEF.md
# Interleaved Converter Sample Reassembler

This block takes the parallel sample lanes of a two-channel, time-interleaved converter that is running with its channels half a sample clock apart, and rebuilds a single sample stream in true time order. The two channels (called Q and I here) take turns, so the rebuilt stream alternates between them. The block runs on the converter's data clock. Each sample is 12 bits wide.

A mode input chooses how the lanes arrive. In quad mode, four samples come in parallel on each rising data clock edge: a delayed Q lane, a delayed I lane, a Q lane and an I lane. In that order they run from earliest to latest. In double-rate mode, only the Q and I lanes are used, and each lane carries a new sample on both edges of the data clock. Q is the earlier sample of each pair. The falling-edge pair is moved into the rising-edge domain and placed after the rising-edge pair.

Either way, one group of four samples is formed per input beat. Groups wait in a small FIFO. A valid/ready output sends them one sample per beat, earliest first. Each sample carries a channel tag. A group that arrives when the FIFO is full is discarded and sets a sticky overflow flag. A change of mode discards everything the block holds.

Top module: `ilv_reassembler`

## Requirements
- R1: In quad mode (mode = 0), a group captured on a rising edge with in_valid high is emitted as lane_dq, lane_di, lane_q, lane_i, in that order.
- R2: In double-rate mode (mode = 1), a group is formed from the lane_q/lane_i pair captured on a rising edge with in_valid high and the pair captured on the falling edge that follows it. It is emitted as rising lane_q, rising lane_i, falling lane_q, falling lane_i.
- R3: out_tag is 0 for a Q-lane sample (slots 0 and 2 of a group) and 1 for an I-lane sample (slots 1 and 3), so consecutive beats alternate 0, 1, 0, 1.
- R4: While out_valid is high and out_ready is low, out_valid, out_data and out_tag hold their values. The one exception is a mode change.
- R5: With the output stalled, the block keeps five groups (four in the FIFO and one being emitted). Later groups are dropped, and the groups already held are neither lost nor altered.
- R6: A dropped group sets overflow on the next edge. overflow then stays high until reset.
- R7: When mode differs from the mode in use at an edge, every held and partly emitted sample is discarded at that edge. out_valid is low afterwards, no input is captured in that cycle, and later groups follow the new mode.
- R8: Reset (rst_n low at a rising edge) clears out_valid, overflow and the FIFO.
- R9: No group is formed from a rising edge at which in_valid is low, whatever the lanes carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter data clock; both edges used in double-rate mode |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = quad parallel lanes, 1 = two lanes at double rate |
| in_valid | input | 1 | Lanes carry a group on this rising edge |
| lane_dq | input | 12 | Delayed Q lane (quad mode only) |
| lane_di | input | 12 | Delayed I lane (quad mode only) |
| lane_q | input | 12 | Q lane |
| lane_i | input | 12 | I lane |
| out_valid | output | 1 | A sample is presented |
| out_ready | input | 1 | Consumer accepts the presented sample |
| out_data | output | 12 | Sample in time order |
| out_tag | output | 1 | Channel of the sample: 0 = Q, 1 = I |
| overflow | output | 1 | Sticky: a group was dropped |

## Verification
The bench sweeps every 12-bit code through the lanes in both modes. It arranges the values so that the correct time order comes out as a plain ascending count, which makes a swapped lane pair, or rising and falling pairs taken out of order, show up at once as a value mismatch. The stalls are pseudo-regular, so a group handed over on the wrong cycle, or data that moves under a stall, repeats or skips a code. A stalled burst of six groups checks that the fifth is kept and the sixth is lost: an off-by-one capacity keeps one group too many or too few, and a flag that is not sticky reads low afterwards. A mode change in the middle of a group checks that nothing stale leaks out afterwards and that the new lane order is used from then on.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic {
    MODE_QUAD = 1'b0,
    MODE_DDR  = 1'b1
  } ilv_mode_e;

  // samples per group in either capture style
  localparam int GROUP_LANES = 4;

  localparam logic TAG_Q = 1'b0;
  localparam logic TAG_I = 1'b1;

endpackage

// File: rtl/ilv_capture.sv
module ilv_capture
  import ilv_pkg::*;
#(
  parameter  int SW = 12,
  localparam int GW = GROUP_LANES * SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ilv_mode_e     mode,
  input  logic          flush,
  input  logic          in_valid,
  input  logic [SW-1:0] lane_dq,
  input  logic [SW-1:0] lane_di,
  input  logic [SW-1:0] lane_q,
  input  logic [SW-1:0] lane_i,
  output logic          grp_vld,
  output logic [GW-1:0] grp_data
);

  // slot 0 is the earliest sample and sits in the low bits
  function automatic logic [GW-1:0] pack_group(input logic [SW-1:0] s0,
                                               input logic [SW-1:0] s1,
                                               input logic [SW-1:0] s2,
                                               input logic [SW-1:0] s3);
    return {s3, s2, s1, s0};
  endfunction

  logic [SW-1:0] rise_q, rise_i;
  logic [SW-1:0] fall_q, fall_i;
  logic          rise_vld;

  // falling-edge half of a double-rate pair
  always_ff @(negedge clk) begin
    fall_q <= lane_q;
    fall_i <= lane_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_vld <= 1'b0;
      grp_vld  <= 1'b0;
    end else if (flush) begin
      rise_vld <= 1'b0;
      grp_vld  <= 1'b0;
    end else begin
      rise_vld <= in_valid && (mode == MODE_DDR);
      if (mode == MODE_QUAD) grp_vld <= in_valid;
      else                   grp_vld <= rise_vld;
    end
  end

  always_ff @(posedge clk) begin
    rise_q <= lane_q;
    rise_i <= lane_i;
    if (mode == MODE_QUAD) grp_data <= pack_group(lane_dq, lane_di, lane_q, lane_i);
    else                   grp_data <= pack_group(rise_q, rise_i, fall_q, fall_i);
  end

endmodule

// File: rtl/ilv_group_fifo.sv
module ilv_group_fifo #(
  parameter  int W     = 48,
  parameter  int DEPTH = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         drop,
  output logic [CW-1:0] fill
);

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, wr_ok, rd_ok;

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign wr_ok   = wr_en && !full;
  assign rd_ok   = rd_en && !empty;
  assign drop    = wr_en && full;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (wr_ok) wr_ptr <= next_ptr(wr_ptr);
      if (rd_ok) rd_ptr <= next_ptr(rd_ptr);
      fill <= fill + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

endmodule

// File: rtl/ilv_serializer.sv
module ilv_serializer
  import ilv_pkg::*;
#(
  parameter  int SW = 12,
  localparam int GW = GROUP_LANES * SW,
  localparam int IW = $clog2(GROUP_LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          grp_avail,
  input  logic [GW-1:0] grp_data,
  output logic          grp_take,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_data,
  output logic          out_tag,
  output logic          fire
);

  function automatic logic [SW-1:0] pick_sample(input logic [GW-1:0] g,
                                                input logic [IW-1:0] i);
    return g[int'(i)*SW +: SW];
  endfunction

  // even slots come from the Q channel, odd slots from I
  function automatic logic lane_tag(input logic [IW-1:0] i);
    return i[0] ? TAG_I : TAG_Q;
  endfunction

  logic          busy;
  logic [IW-1:0] idx;
  logic [GW-1:0] hold;
  logic          last_beat;

  assign fire      = busy && out_ready;
  assign last_beat = (idx == IW'(GROUP_LANES - 1));
  assign grp_take  = !flush && grp_avail && (!busy || (fire && last_beat));
  assign out_valid = busy;
  assign out_data  = pick_sample(hold, idx);
  assign out_tag   = lane_tag(idx);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (grp_take) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (fire && last_beat) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (fire) begin
      idx <= idx + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (grp_take) hold <= grp_data;
  end

endmodule

// File: rtl/ilv_reassembler.sv
module ilv_reassembler
  import ilv_pkg::*;
#(
  parameter  int SAMPLE_W   = 12,
  parameter  int FIFO_DEPTH = 4,
  localparam int GROUP_W    = GROUP_LANES * SAMPLE_W,
  localparam int FILL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] lane_dq,
  input  logic [SAMPLE_W-1:0] lane_di,
  input  logic [SAMPLE_W-1:0] lane_q,
  input  logic [SAMPLE_W-1:0] lane_i,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_tag,
  output logic                overflow
);

  ilv_mode_e mode_req, mode_q;
  logic      flush_evt, drop_evt, fire_evt;
  logic      grp_vld, grp_take, fifo_empty;
  logic [GROUP_W-1:0] grp_data, fifo_data;
  logic [FILL_W-1:0]  fifo_fill;

  assign mode_req = ilv_mode_e'(mode);

  // the active mode follows the input one edge later; a difference flushes
  always_ff @(posedge clk) mode_q <= mode_req;
  assign flush_evt = rst_n && (mode_req != mode_q);

  ilv_capture #(.SW(SAMPLE_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .flush    (flush_evt),
    .in_valid (in_valid),
    .lane_dq  (lane_dq),
    .lane_di  (lane_di),
    .lane_q   (lane_q),
    .lane_i   (lane_i),
    .grp_vld  (grp_vld),
    .grp_data (grp_data)
  );

  ilv_group_fifo #(.W(GROUP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush_evt),
    .wr_en   (grp_vld),
    .wr_data (grp_data),
    .rd_en   (grp_take),
    .rd_data (fifo_data),
    .empty   (fifo_empty),
    .drop    (drop_evt),
    .fill    (fifo_fill)
  );

  ilv_serializer #(.SW(SAMPLE_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_evt),
    .grp_avail (!fifo_empty),
    .grp_data  (fifo_data),
    .grp_take  (grp_take),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_tag   (out_tag),
    .fire      (fire_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        overflow <= 1'b0;
    else if (drop_evt) overflow <= 1'b1;
  end

endmodule

// File: rtl/ilv_reassembler_chk.sv
module ilv_reassembler_chk #(
  parameter int SW    = 12,
  parameter int DEPTH = 4,
  parameter int FW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [SW-1:0] out_data,
  input logic          out_tag,
  input logic          overflow,
  input logic          flush_evt,
  input logic          drop_evt,
  input logic          fire_evt,
  input logic [FW-1:0] fifo_fill
);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush_evt) |=>
      (out_valid && $stable(out_data) && $stable(out_tag)));

  // R3
  tag_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_evt && !flush_evt) |=> (!out_valid || (out_tag != $past(out_tag))));

  // R6
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overflow);

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> !out_valid);

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_fill <= FW'(DEPTH));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !overflow && (fifo_fill == '0)));

endmodule

bind ilv_reassembler ilv_reassembler_chk #(
  .SW(SAMPLE_W), .DEPTH(FIFO_DEPTH), .FW(FILL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_tag   (out_tag),
  .overflow  (overflow),
  .flush_evt (flush_evt),
  .drop_evt  (drop_evt),
  .fire_evt  (fire_evt),
  .fifo_fill (fifo_fill)
);

// File: tb/ilv_reassembler_tb.sv
module ilv_reassembler_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] lane_dq = '0, lane_di = '0, lane_q = '0, lane_i = '0;
  logic        out_valid, out_ready, out_tag, overflow;
  logic [11:0] out_data;

  int total = 0, bad = 0, beats = 0, cyc = 0, rdy_mode = 0;
  bit done = 0;
  string cur_req = "R1";
  int exp_d[$];
  int exp_t[$];
  bit prev_stall = 0;
  int prev_d = 0, prev_t = 0;

  ilv_reassembler u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
    .lane_dq(lane_dq), .lane_di(lane_di), .lane_q(lane_q), .lane_i(lane_i),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_tag(out_tag), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // ready pattern: 0 always, 1 three of four, 2 never, 4 manual
  always @(negedge clk) begin
    #2;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 4) != 3;
      2: out_ready = 1'b0;
      default: ;
    endcase
  end

  // sample just before each rising edge
  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      if (prev_stall && out_valid) begin
        chk(out_data == 12'(prev_d), "R4 data held", out_data, prev_d);
        chk(out_tag == prev_t[0], "R4 tag held", out_tag, prev_t);
      end
      if (out_valid && out_ready) begin
        beats++;
        if (exp_d.size() == 0) chk(0, "R9 unexpected beat", out_data, -1);
        else begin
          int d, t;
          d = exp_d.pop_front();
          t = exp_t.pop_front();
          chk(int'(out_data) == d, cur_req, out_data, d);
          chk(int'(out_tag) == t, "R3 tag", out_tag, t);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_d = out_data;
      prev_t = out_tag;
    end else prev_stall = 0;
  end

  task automatic push4(input int a, input int b, input int c, input int d);
    exp_d.push_back(a); exp_t.push_back(0);
    exp_d.push_back(b); exp_t.push_back(1);
    exp_d.push_back(c); exp_t.push_back(0);
    exp_d.push_back(d); exp_t.push_back(1);
  endtask

  task automatic send_quad(input int a, input int b, input int c, input int d, input bit keep);
    @(negedge clk); #2;
    lane_dq = 12'(a); lane_di = 12'(b); lane_q = 12'(c); lane_i = 12'(d);
    in_valid = 1'b1;
    if (keep) push4(a, b, c, d);
  endtask

  task automatic send_ddr(input int a, input int b, input int c, input int d);
    @(negedge clk); #2;
    lane_q = 12'(a); lane_i = 12'(b); in_valid = 1'b1;
    @(posedge clk); #2;
    lane_q = 12'(c); lane_i = 12'(d); in_valid = 1'b0;
    push4(a, b, c, d);
  endtask

  // R9: lanes carry junk while in_valid is low
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #2;
      in_valid = 1'b0;
      lane_dq = 12'(k * 37); lane_di = 12'(k * 91); lane_q = 12'hABC; lane_i = 12'(k);
    end
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 4000 && exp_d.size() != 0; k++) @(posedge clk);
    chk(exp_d.size() == 0, req, exp_d.size(), 0);
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk); #2;
    mode = m;
    @(posedge clk); #1;
    exp_d.delete();
    exp_t.delete();
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    if (!done) begin
      chk(0, "watchdog expired", cyc, WD_CYCLES);
      summary();
      $finish;
    end
  end

  initial begin
    int b0;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #4;
    // R8 reset state
    chk(out_valid == 1'b0, "R8 out_valid after reset", out_valid, 0);
    chk(overflow == 1'b0, "R8 overflow after reset", overflow, 0);

    // R1 quad sweep over every code, ascending in time order
    cur_req = "R1 quad order";
    rdy_mode = 1;
    for (int g = 0; g < 1024; g++) begin
      send_quad(4*g, 4*g+1, 4*g+2, 4*g+3, 1);
      idle(7);
    end
    drain("R1 quad drain");
    b0 = beats;
    idle(20);
    chk(beats == b0, "R9 no beats while idle", beats - b0, 0);

    // R2 double-rate sweep
    set_mode(1'b1);
    idle(3);
    cur_req = "R2 double-rate order";
    for (int g = 0; g < 1024; g++) begin
      send_ddr(4*g, 4*g+1, 4*g+2, 4*g+3);
      idle(7);
    end
    drain("R2 double-rate drain");

    // R5 capacity and R6 overflow with a stalled output
    set_mode(1'b0);
    cur_req = "R5 held groups";
    rdy_mode = 2;
    idle(3);
    chk(overflow == 1'b0, "R6 no overflow before burst", overflow, 0);
    for (int g = 0; g < 6; g++) send_quad(2000 + 4*g, 2001 + 4*g, 2002 + 4*g, 2003 + 4*g, g < 5);
    idle(4);
    #2;
    chk(overflow == 1'b1, "R6 overflow after drop", overflow, 1);
    chk(out_valid == 1'b1, "R5 first group presented", out_valid, 1);
    chk(out_data == 12'd2000, "R5 first sample held", out_data, 2000);
    rdy_mode = 0;
    drain("R5 five groups delivered");
    b0 = beats;
    idle(10);
    chk(beats == b0, "R5 sixth group dropped", beats - b0, 0);
    chk(overflow == 1'b1, "R6 overflow sticky", overflow, 1);

    // R7 mode change in the middle of a group
    cur_req = "R7 before change";
    rdy_mode = 2;
    send_quad(3000, 3001, 3002, 3003, 1);
    send_quad(3004, 3005, 3006, 3007, 1);
    idle(5);
    rdy_mode = 4;
    @(negedge clk); #2 out_ready = 1'b1;
    @(negedge clk); #2 out_ready = 1'b1;
    @(negedge clk); #2 out_ready = 1'b0;
    chk(exp_d.size() == 6, "R7 two beats taken", exp_d.size(), 6);
    set_mode(1'b1);
    @(negedge clk); #4;
    chk(out_valid == 1'b0, "R7 out_valid after change", out_valid, 0);
    rdy_mode = 0;
    b0 = beats;
    idle(12);
    chk(beats == b0, "R7 stale samples discarded", beats - b0, 0);
    cur_req = "R7 new mode order";
    for (int g = 0; g < 3; g++) send_ddr(100 + 4*g, 101 + 4*g, 102 + 4*g, 103 + 4*g);
    idle(2);
    drain("R7 new mode drain");

    // R8 reset clears the sticky flag
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_d.delete();
    exp_t.delete();
    #4;
    chk(overflow == 1'b0, "R8 overflow cleared by reset", overflow, 0);
    chk(out_valid == 1'b0, "R8 out_valid cleared by reset", out_valid, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule